// File: doc/BRIEF.md
# JTAG TAP Scan Master

This block drives a single four-wire JTAG target from a small command port. Three commands are supported: a TAP reset, an 8-bit instruction-register scan and a 16-bit data-register scan. The engine produces TCK from the system clock through a programmable half-period counter and sequences TMS and TDI. For scans it samples TDO and returns the captured word together with a one-cycle done pulse. Every command starts and ends with the target TAP in Run-Test/Idle.

Between scans the TDI wire is reused as a separate target clock (TCLK): while the engine is idle, TDI follows the `tclkLevel` input. The level present on TDI when a command is accepted is held for every non-shift TCK pulse and is put back on TDI as soon as the last data bit has been shifted. Before it brings the TAP to Run-Test/Idle, the reset command toggles TMS with TCK held high. Some targets use this pattern for a fuse check. Instruction opcodes are given in logical bit order and shifted with their bit order reversed.

Top module: `tap_scan_master`

## Requirements
- R1: After reset, tck=1, tms=1, tdi=1, busy=0, done=0 and rdData=0.
- R2: Command code 2'b00 (TAP reset) first holds TCK high for five steps of HALF_CYC cycles each, with TMS at 1,0,1,0,1. It then gives six TCK pulses with TMS=1 and one pulse with TMS=0. It returns rdData=0.
- R3: Command code 2'b01 (instruction scan) gives TCK pulses with TMS 1,1,0,0 and then shifts 8 bits taken from cmdData[7:0].
- R4: Command code 2'b10 (data scan) gives TCK pulses with TMS 1,0,0 and then shifts 16 bits taken from cmdData[15:0].
- R5: TDI bits leave most-significant first. The TDO bit sampled on the first shift pulse lands in the top bit of the result. An instruction scan returns the 8 captured bits in rdData[7:0] with rdData[15:8]=0.
- R6: TMS is 1 on the last shift pulse and 1 on the pulse that follows it. A final pulse with TMS=0 then ends every scan.
- R7: The instruction byte is shifted bit-reversed: cmdData[7:0]=0x13 appears on TDI as 1,1,0,0,1,0,0,0.
- R8: While idle, TDI follows tclkLevel one cycle later. During a command, every non-shift pulse carries the TDI level present at acceptance, even if tclkLevel changes meanwhile.
- R9: Each TCK low and high phase lasts HALF_CYC system cycles, and TDI does not change while TCK is high. Done rises 19, 28 or 42 times HALF_CYC cycles after acceptance for reset, instruction and data commands respectively.
- R10: A command is taken only when busy=0 and cmdValid=1. Commands presented while busy and code 2'b11 have no effect.
- R11: Busy is high from the cycle after acceptance until done rises. Done lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | Command code (00 reset, 01 instruction, 10 data, 11 none) |
| cmdData | input | 16 | Scan payload |
| tclkLevel | input | 1 | TCLK level driven on TDI while idle |
| tdo | input | 1 | Target data out |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data in, carries TCLK between scans |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Captured TDO word |

## Verification
A controller stuck in the wrong pulse index or scan kind shows at the TMS pins at the very next TCK rising edge, so the bench compares TMS and TDI on every rising TCK edge. A shift register that slips or loads the wrong bit order first shows as a wrong TDI bit inside the shift window, and at the latest as a wrong rdData when done rises. A miscounted half-period counter moves the done pulse away from the cycle count the command implies, which the bench measures to the cycle. Saving the wrong TCLK level shows on the first navigation pulse, because the bench changes tclkLevel in the middle of a scan.

// File: rtl/tap_scan_pkg.sv
package tap_scan_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_IR    = 2'b01,
    OP_DR    = 2'b10,
    OP_NONE  = 2'b11
  } tapOp_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_STATIC = 2'b01,
    ST_LOW    = 2'b10,
    ST_HIGH   = 2'b11
  } engState_e;

  // strobes from the sequencer to the pin/shift datapath
  typedef struct packed {
    logic accept;    // command taken this edge
    logic wordIr;    // current command is an instruction scan
    logic wordDr;    // current command is a data scan
    logic drive;     // new phase or step begins: load pin values
    logic idle;      // engine idle after this edge
    logic tckVal;
    logic tmsVal;
    logic tdiShift;  // TDI from shift register MSB instead of saved TCLK
    logic sample;    // capture TDO into shift register
    logic finish;    // command complete
  } ctrlStrobe_t;

endpackage

// File: rtl/tap_scan_ctrl.sv
module tap_scan_ctrl
  import tap_scan_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int IR_W     = 8,
  parameter int DR_W     = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  tapOp_e      cmdOp,
  output logic        busy,
  output ctrlStrobe_t stb
);

  localparam int FUSE_STEPS = 5;
  localparam int RST_PULSES = 7;
  localparam int RST_ONES   = 6;
  localparam int IR_NAV     = 4;
  localparam int DR_NAV     = 3;
  localparam int TAIL       = 2;
  localparam int IR_TOTAL   = IR_NAV + IR_W + TAIL;
  localparam int DR_TOTAL   = DR_NAV + DR_W + TAIL;
  localparam int MAX_TOTAL  = (IR_TOTAL > DR_TOTAL) ? IR_TOTAL : DR_TOTAL;
  localparam int PULSE_W    = $clog2(MAX_TOTAL + 1);
  localparam int DIV_W      = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int STEP_W     = $clog2(FUSE_STEPS);

  engState_e           stQ, stD;
  tapOp_e              kindQ, kindD;
  logic [DIV_W-1:0]    divQ, divD;
  logic [STEP_W-1:0]   stepQ, stepD;
  logic [PULSE_W-1:0]  pulseQ, pulseD;

  function automatic int navLen(tapOp_e k);
    case (k)
      OP_IR:   return IR_NAV;
      OP_DR:   return DR_NAV;
      default: return RST_PULSES;
    endcase
  endfunction

  function automatic int shLen(tapOp_e k);
    case (k)
      OP_IR:   return IR_W;
      OP_DR:   return DR_W;
      default: return 0;
    endcase
  endfunction

  function automatic int totLen(tapOp_e k);
    if (k == OP_RESET) return RST_PULSES;
    return navLen(k) + shLen(k) + TAIL;
  endfunction

  function automatic logic inShift(tapOp_e k, int p);
    return (p >= navLen(k)) && (p < navLen(k) + shLen(k));
  endfunction

  function automatic logic pulseTms(tapOp_e k, int p);
    int nav, sh;
    nav = navLen(k);
    sh  = shLen(k);
    if (k == OP_RESET)   return p < RST_ONES;
    if (p < nav)         return p < nav - 2;
    if (p < nav + sh)    return p == nav + sh - 1;
    return p == nav + sh;
  endfunction

  logic lastDiv;
  int   pQ, pD;

  assign lastDiv = (int'(divQ) == HALF_CYC - 1);
  assign pQ      = int'(pulseQ);
  assign pD      = int'(pulseD);
  assign busy    = (stQ != ST_IDLE);

  always_comb begin
    stD    = stQ;
    kindD  = kindQ;
    divD   = divQ;
    stepD  = stepQ;
    pulseD = pulseQ;
    stb    = '0;
    case (stQ)
      ST_IDLE: begin
        if (cmdValid && cmdOp != OP_NONE) begin
          kindD      = cmdOp;
          divD       = '0;
          stepD      = '0;
          pulseD     = '0;
          stD        = (cmdOp == OP_RESET) ? ST_STATIC : ST_LOW;
          stb.accept = 1'b1;
          stb.drive  = 1'b1;
        end
      end
      ST_STATIC: begin
        if (lastDiv) begin
          divD      = '0;
          stb.drive = 1'b1;
          if (int'(stepQ) == FUSE_STEPS - 1) stD = ST_LOW;
          else stepD = stepQ + STEP_W'(1);
        end else begin
          divD = divQ + DIV_W'(1);
        end
      end
      ST_LOW: begin
        if (lastDiv) begin
          divD      = '0;
          stD       = ST_HIGH;
          stb.drive = 1'b1;
        end else begin
          divD = divQ + DIV_W'(1);
        end
      end
      default: begin
        if (divQ == '0 && inShift(kindQ, pQ)) stb.sample = 1'b1;
        if (lastDiv) begin
          divD = '0;
          if (pQ == totLen(kindQ) - 1) begin
            stD        = ST_IDLE;
            stb.finish = 1'b1;
          end else begin
            stD       = ST_LOW;
            pulseD    = pulseQ + PULSE_W'(1);
            stb.drive = 1'b1;
          end
        end else begin
          divD = divQ + DIV_W'(1);
        end
      end
    endcase
    // pin values belong to the state entered at this edge
    stb.wordIr   = (kindD == OP_IR);
    stb.wordDr   = (kindD == OP_DR);
    stb.idle     = (stD == ST_IDLE);
    stb.tckVal   = (stD != ST_LOW);
    stb.tmsVal   = (stD == ST_STATIC) ? ~stepD[0] : pulseTms(kindD, pD);
    stb.tdiShift = (stD == ST_LOW || stD == ST_HIGH) && inShift(kindD, pD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ    <= ST_IDLE;
      kindQ  <= OP_NONE;
      divQ   <= '0;
      stepQ  <= '0;
      pulseQ <= '0;
    end else begin
      stQ    <= stD;
      kindQ  <= kindD;
      divQ   <= divD;
      stepQ  <= stepD;
      pulseQ <= pulseD;
    end
  end

endmodule

// File: rtl/tap_scan_dp.sv
module tap_scan_dp
  import tap_scan_pkg::*;
#(
  parameter int IR_W   = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              tclkLevel,
  input  logic              tdo,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic              done,
  output logic [DATA_W-1:0] rdData
);

  localparam int PAD_W = DATA_W - IR_W;

  logic [DATA_W-1:0] shReg, shNext, loadVal;
  logic [IR_W-1:0]   irRev;
  logic              savedQ, savedNext;
  logic              tckQ, tmsQ, tdiQ, doneQ;
  logic [DATA_W-1:0] rdQ;

  // instruction byte is shifted with its bit order mirrored
  for (genvar i = 0; i < IR_W; i++) begin : g_rev
    assign irRev[i] = cmdData[IR_W-1-i];
  end

  always_comb begin
    if (stb.wordIr)      loadVal = {irRev, {PAD_W{1'b0}}};
    else if (stb.wordDr) loadVal = cmdData;
    else                 loadVal = '0;
  end

  always_comb begin
    if (stb.sample)      shNext = {shReg[DATA_W-2:0], tdo};
    else if (stb.accept) shNext = loadVal;
    else                 shNext = shReg;
  end

  assign savedNext = stb.accept ? tdiQ : savedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      savedQ <= 1'b1;
      tckQ   <= 1'b1;
      tmsQ   <= 1'b1;
      tdiQ   <= 1'b1;
      doneQ  <= 1'b0;
      rdQ    <= '0;
    end else begin
      shReg  <= shNext;
      savedQ <= savedNext;
      doneQ  <= stb.finish;
      if (stb.idle) begin
        tckQ <= 1'b1;
        tdiQ <= tclkLevel;
      end else if (stb.drive) begin
        tckQ <= stb.tckVal;
        tmsQ <= stb.tmsVal;
        tdiQ <= stb.tdiShift ? shNext[DATA_W-1] : savedNext;
      end
      if (stb.finish) begin
        if (stb.wordIr)      rdQ <= {{PAD_W{1'b0}}, shReg[IR_W-1:0]};
        else if (stb.wordDr) rdQ <= shReg;
        else                 rdQ <= '0;
      end
    end
  end

  assign tck    = tckQ;
  assign tms    = tmsQ;
  assign tdi    = tdiQ;
  assign done   = doneQ;
  assign rdData = rdQ;

endmodule

// File: rtl/tap_scan_master.sv
module tap_scan_master
  import tap_scan_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int IR_W     = 8,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              tclkLevel,
  input  logic              tdo,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData
);

  ctrlStrobe_t stb;

  tap_scan_ctrl #(
    .HALF_CYC (HALF_CYC),
    .IR_W     (IR_W),
    .DR_W     (DATA_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (tapOp_e'(cmdOp)),
    .busy     (busy),
    .stb      (stb)
  );

  tap_scan_dp #(
    .IR_W   (IR_W),
    .DATA_W (DATA_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cmdData   (cmdData),
    .tclkLevel (tclkLevel),
    .tdo       (tdo),
    .tck       (tck),
    .tms       (tms),
    .tdi       (tdi),
    .done      (done),
    .rdData    (rdData)
  );

endmodule

// File: rtl/tap_scan_chk.sv
module tap_scan_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic       tck,
  input logic       tdi,
  input logic       busy,
  input logic       done
);

  // R11: done is a single-cycle pulse
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: done rises exactly as busy falls
  a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  // R10: a valid command while idle starts the engine
  a_r10_accept: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && cmdOp != 2'b11) |=> busy);

  // R10: the unused code leaves the engine idle
  a_r10_none_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && cmdOp == 2'b11) |=> !busy);

  // R9: TDI holds while TCK is high inside a command
  a_r9_tdi_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && tck && $past(tck)) |-> $stable(tdi));

  // R9: TCK only goes low while a command runs
  a_r9_tck_low_busy: assert property (@(posedge clk) disable iff (!rstN)
    !tck |-> busy);

endmodule

bind tap_scan_master tap_scan_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .tck      (tck),
  .tdi      (tdi),
  .busy     (busy),
  .done     (done)
);

// File: tb/sim_tap_scan_master.sv
module sim_tap_scan_master;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int WATCHDOG   = 200000;

  typedef struct {
    bit          isResult;
    logic [15:0] val;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'b11;
  logic [15:0] cmdData = '0;
  logic        tclkLevel = 1'b1;
  logic        tdo = 1'b0;
  logic        tck, tms, tdi, busy, done;
  logic [15:0] rdData;

  item_t expQ[$];
  bit    repBits[0:31];
  int    pulseCnt = 0;
  int    nChk = 0;
  int    nFail = 0;
  logic  tclkNow = 1'b1;

  tap_scan_master #(.HALF_CYC(HALF)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .tclkLevel(tclkLevel), .tdo(tdo),
    .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done),
    .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // target model: count rising TCK edges, present the next reply bit after each falling edge
  initial forever begin
    @(posedge tck);
    pulseCnt = pulseCnt + 1;
  end

  initial forever begin
    @(negedge tck);
    #1;
    tdo = repBits[pulseCnt];
  end

  // scoreboard monitor: pin values on each rising TCK edge
  initial forever begin
    @(posedge tck);
    #1;
    if (busy) begin
      if (expQ.size() == 0 || expQ[0].isResult) begin
        check(1'b0, "R2", "unexpected TCK pulse {tms,tdi}", {tms, tdi}, 0);
      end else begin
        item_t it;
        it = expQ.pop_front();
        check({tms, tdi} == it.val[1:0], it.req, "pulse {tms,tdi}",
              {tms, tdi}, it.val[1:0]);
      end
    end
  end

  // scoreboard monitor: returned word on done
  initial forever begin
    @(negedge clk);
    if (rstN && done) begin
      if (expQ.size() == 0 || !expQ[0].isResult) begin
        check(1'b0, "R11", "done with pulses outstanding", expQ.size(), 0);
        expQ.delete();
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(rdData == it.val, it.req, "rdData", rdData, it.val);
      end
    end
  end

  task automatic pushPulse(input bit t, input bit d, input string req);
    item_t it;
    it.isResult = 1'b0;
    it.val      = {14'b0, t, d};
    it.req      = req;
    expQ.push_back(it);
  endtask

  task automatic runCmd(input logic [1:0] op, input logic [15:0] data,
                        input logic [15:0] reply, input bit poke,
                        input string req);
    logic        s;
    logic [7:0]  b;
    int          nav, len, total, idx, cnt;
    item_t       res;
    s = tclkNow;
    for (int i = 0; i < 32; i++) repBits[i] = 1'b0;
    if (op == 2'b00) begin
      for (int i = 0; i < 6; i++) pushPulse(1'b1, s, "R2");
      pushPulse(1'b0, s, "R2");
      nav = 7; len = 0; total = 19 * HALF;
      res.val = 16'h0000;
    end else begin
      if (op == 2'b01) begin
        for (int i = 0; i < 8; i++) b[i] = data[7-i];
        pushPulse(1'b1, s, "R3"); pushPulse(1'b1, s, "R3");
        pushPulse(1'b0, s, "R3"); pushPulse(1'b0, s, "R3");
        for (int i = 7; i >= 0; i--) pushPulse(i == 0, b[i], "R7");
        nav = 4; len = 8; total = 28 * HALF;
        res.val = {8'h00, reply[7:0]};
      end else begin
        pushPulse(1'b1, s, "R4"); pushPulse(1'b0, s, "R4"); pushPulse(1'b0, s, "R4");
        for (int i = 15; i >= 0; i--) pushPulse(i == 0, data[i], "R4");
        nav = 3; len = 16; total = 42 * HALF;
        res.val = reply;
      end
      pushPulse(1'b1, s, "R6");
      pushPulse(1'b0, s, "R8");
      for (int i = 0; i < len; i++) repBits[nav + i] = reply[len - 1 - i];
    end
    res.isResult = 1'b1;
    res.req      = "R5";
    expQ.push_back(res);
    pulseCnt = 0;

    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdData = data;
    cnt = 0;
    while (cnt < total + 60) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        cmdValid = 1'b0;
        check(busy == 1'b1, "R11", "busy after accept", busy, 1);
      end
      if (poke && cnt == 3) begin
        tclkLevel = ~tclkLevel;
        tclkNow   = tclkLevel;
      end
      if (poke && cnt == 5) begin
        cmdValid = 1'b1; cmdOp = 2'b00; cmdData = 16'hFFFF;
      end
      if (poke && cnt == 6) cmdValid = 1'b0;
      if (op == 2'b00 && cnt <= 5 * HALF && ((cnt - 1) % HALF) == 0) begin
        idx = (cnt - 1) / HALF;
        check(tck == 1'b1, "R2", "tck high during fuse step", tck, 1);
        check(tms == ((idx == 0) ? 1'b1 : ~idx[0]), "R2", "fuse step tms",
              tms, (idx == 0) ? 1 : ~idx[0]);
      end
      if (done) break;
    end
    check(cnt == total + 1, req, "cycles to done (R9)", cnt, total + 1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R11", "done one cycle, idle after",
          {done, busy}, 0);
    check(expQ.size() == 0, req, "outstanding expected items", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check(tck == 1 && tms == 1 && tdi == 1, "R1", "pins {tck,tms,tdi} in reset",
          {tck, tms, tdi}, 7);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && rdData == 0, "R1", "busy/done/rdData after reset",
          {busy, done, rdData}, 0);

    // idle TDI follows tclkLevel
    tclkLevel = 1'b0; tclkNow = 1'b0;
    repeat (2) @(negedge clk);
    check(tdi == 1'b0, "R8", "idle tdi follows tclkLevel low", tdi, 0);
    tclkLevel = 1'b1; tclkNow = 1'b1;
    repeat (2) @(negedge clk);
    check(tdi == 1'b1, "R8", "idle tdi follows tclkLevel high", tdi, 1);

    runCmd(2'b00, 16'h1234, 16'h0000, 1'b0, "R2");
    runCmd(2'b01, 16'h0013, 16'h00A5, 1'b0, "R7");
    runCmd(2'b10, 16'h2401, 16'h8C3E, 1'b0, "R4");
    tclkLevel = 1'b0; tclkNow = 1'b0;
    repeat (2) @(negedge clk);
    runCmd(2'b10, 16'hFFFF, 16'h0001, 1'b1, "R10");
    repeat (2) @(negedge clk);
    runCmd(2'b01, 16'h0080, 16'h0081, 1'b1, "R8");
    runCmd(2'b10, 16'h0001, 16'hFFFE, 1'b0, "R5");

    // unused command code
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'b11; cmdData = 16'hAAAA;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check(busy == 0 && tck == 1, "R10", "code 11 ignored {busy,tck}", {busy, tck}, 1);
    end

    runCmd(2'b00, 16'h0000, 16'h0000, 1'b0, "R2");

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule